// File: doc/BRIEF.md
# Dual-Mode Clocked FIFO Core

A first-in first-out buffer that moves 36-bit words from a write port to a read port, each port on its own clock. The two clocks may be unrelated or the same. Storage is a small RAM of power-of-two depth (64 words by default). Pointer state crosses between the clock domains in Gray code through two-flop synchronizers. Every status flag is registered in the domain that uses it.

The timing mode is captured from `fwft_sel_i` while master reset is held. In standard mode a stored word reaches `rdata_o` only after a read request. The combined flags then report full on the write side and empty on the read side. In fall-through mode the oldest word is placed on `rdata_o` without a request. The flags then report input-ready and output-ready, and each further word needs a read.

Thresholds for the almost flags are plain inputs. A partial reset flushes the contents and keeps the captured mode. A qualified retransmit moves only the read pointer back to location zero, so data already written is read again.

Top module: `dmf_fifo`

## Requirements
- R1: The mode (`fwft_sel_i`: 0 = standard, 1 = fall-through) is sampled on clock edges while `rst_ni` is low. Changing `fwft_sel_i` after reset has no effect until the next master reset.
- R2: In standard mode a written word does not reach `rdata_o` until a read is accepted. The word appears on `rdata_o` one read clock after the accepted read. `rd_flag_o`=1 means empty and `wr_flag_o`=1 means full.
- R3: In fall-through mode the oldest word is driven on `rdata_o` with no read request, and `rd_flag_o`=1 means that word is valid. A read while valid advances to the next word. `wr_flag_o`=1 means space is available.
- R4: Every accepted word is returned exactly once and in write order. This holds with the write and read clocks running asynchronously.
- R5: A write while full, or a read while empty or not valid, is ignored. The stored data, the pointers and the held `rdata_o` do not change.
- R6: `almost_empty_o` is 1 when the word count seen by the read side is less than or equal to `ae_lvl_i`.
- R7: `almost_full_o` is 1 when the word count seen by the write side is greater than DEPTH minus `af_lvl_i`.
- R8: After a master reset or a partial reset (`prst_ni` low), the FIFO reports no data and space available, with `almost_empty_o`=1. A partial reset keeps the captured mode.
- R9: A pulse on `rt_i` while `rt_en_i`=1 rewinds only the read pointer to location zero, so the words written since the last reset are read again. When `rt_en_i`=0, `rt_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous on pointers |
| prst_ni | input | 1 | Partial reset, active low, asynchronous |
| fwft_sel_i | input | 1 | Mode select sampled during master reset |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 36 | Write data |
| wr_flag_o | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_full_o | output | 1 | Almost-full flag, write domain |
| af_lvl_i | input | 7 | Almost-full offset from the full boundary |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 36 | Read data |
| rd_flag_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty_o | output | 1 | Almost-empty flag, read domain |
| ae_lvl_i | input | 7 | Almost-empty offset from the empty boundary |
| rt_i | input | 1 | Retransmit request, read domain |
| rt_en_i | input | 1 | Retransmit enable |

## Verification
The bench fills the FIFO past its capacity and counts accepted writes. A design that let a write through while full would accept more than 64 words and corrupt the oldest data on readback. It steps the count across both almost thresholds one word at a time, which exposes off-by-one errors in the comparisons. It flips the mode pin after reset to catch a mode that is not latched. It checks that fall-through data appears with no read, and that standard data does not. It checks that a partial reset keeps fall-through behaviour. It issues a retransmit with the enable both low and high: a wrong design would rewind without permission, or replay the wrong words. Random asynchronous traffic in both modes, with flags used as the only handshake, shows up lost, duplicated or reordered words.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dmf_gray_sync.sv
`timescale 1ns/1ps
module dmf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dmf_ram.sv
`timescale 1ns/1ps
module dmf_ram #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_wr_ctrl.sv
`timescale 1ns/1ps
module dmf_wr_ctrl
  import dmf_pkg::*;
#(
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_sel_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] af_lvl_i,
  input  logic [PW-1:0] rgray_s_i,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          wr_flag_o,
  output logic          almost_full_o
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e    mode_q;
  logic          wrst_n;
  logic [PW-1:0] wbin_q, wbin_n, wgray_q, rbin_s, wcnt_n, af_thr;
  logic          full_q, afull_q, wr_acc;

  assign wrst_n = rst_ni & prst_ni;

  // mode captured only while master reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_sel_i);
  end

  always_comb begin
    wr_acc = wr_en_i & ~full_q;
    wbin_n = wbin_q + PW'(wr_acc);
    rbin_s = g2b(rgray_s_i);
    wcnt_n = wbin_n - rbin_s;
    af_thr = PW'(DEPTH) - af_lvl_i;
  end

  always_ff @(posedge wclk_i or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
      full_q  <= (wcnt_n == PW'(DEPTH));
      afull_q <= (wcnt_n > af_thr);
    end
  end

  assign wgray_o       = wgray_q;
  assign waddr_o       = wbin_q[AW-1:0];
  assign we_o          = wr_acc;
  assign wr_flag_o     = (mode_q == MODE_FWFT) ? ~full_q : full_q;
  assign almost_full_o = afull_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    (wbin_q - rbin_s) <= PW'(DEPTH)); // R5
  AST_FULL_WR_IGNORED: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    (full_q && wr_en_i) |=> $stable(wbin_q)); // R5
  AST_WR_MODE_HELD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (fwft_sel_i != mode_q) |=> $stable(mode_q)); // R1
endmodule

// File: rtl/dmf_rd_ctrl.sv
`timescale 1ns/1ps
module dmf_rd_ctrl
  import dmf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_sel_i,
  input  logic          rd_en_i,
  input  logic          rt_i,
  input  logic          rt_en_i,
  input  logic [PW-1:0] ae_lvl_i,
  input  logic [PW-1:0] wgray_s_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          almost_empty_o
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e    mode_q;
  logic          rrst_n, rt_go, fetch, ov_q, ov_n, empty_q, empty_n, aempty_q;
  logic [PW-1:0] rbin_q, rbin_n, rgray_q, wbin_s, cnt_n;
  logic [DW-1:0] rdata_q;

  assign rrst_n = rst_ni & prst_ni;

  always_ff @(posedge rclk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_sel_i);
  end

  always_comb begin
    rt_go  = rt_i & rt_en_i;
    wbin_s = g2b(wgray_s_i);
    if (mode_q == MODE_FWFT) fetch = (~ov_q | rd_en_i) & ~empty_q;
    else                     fetch = rd_en_i & ~empty_q;
    if (rt_go) begin
      rbin_n = '0;
      ov_n   = 1'b0;
    end else begin
      rbin_n = rbin_q + PW'(fetch);
      ov_n   = (mode_q == MODE_FWFT) ? (fetch | (ov_q & ~rd_en_i)) : 1'b0;
    end
    empty_n = (rbin_n == wbin_s);
    // fall-through word held in the output stage still counts
    cnt_n   = wbin_s - rbin_n + PW'(ov_n);
  end

  always_ff @(posedge rclk_i or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      ov_q     <= 1'b0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      rdata_q  <= '0;
    end else begin
      rbin_q   <= rbin_n;
      rgray_q  <= rbin_n ^ (rbin_n >> 1);
      ov_q     <= ov_n;
      empty_q  <= empty_n;
      aempty_q <= (cnt_n <= ae_lvl_i);
      if (fetch && !rt_go) rdata_q <= rd_word_i;
    end
  end

  assign rgray_o        = rgray_q;
  assign raddr_o        = rbin_q[AW-1:0];
  assign rdata_o        = rdata_q;
  assign rd_flag_o      = (mode_q == MODE_FWFT) ? ov_q : empty_q;
  assign almost_empty_o = aempty_q;

  AST_EMPTY_RD_IGNORED: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    (mode_q == MODE_STD && empty_q && rd_en_i && !rt_i) |=> ($stable(rbin_q) && $stable(rdata_q))); // R5
  AST_FWFT_HOLD: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    (mode_q == MODE_FWFT && ov_q && !rd_en_i && !rt_i) |=> (ov_q && $stable(rdata_q))); // R3
  AST_RT_REWIND: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    (rt_i && rt_en_i) |=> (raddr_o == '0 && !ov_q)); // R9
  AST_RD_MODE_HELD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_sel_i != mode_q) |=> $stable(mode_q)); // R1
endmodule

// File: rtl/dmf_fifo.sv
`timescale 1ns/1ps
module dmf_fifo #(
  parameter int DW = 36,
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_flag_o,
  output logic          almost_full_o,
  input  logic [PW-1:0] af_lvl_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_flag_o,
  output logic          almost_empty_o,
  input  logic [PW-1:0] ae_lvl_i,
  input  logic          rt_i,
  input  logic          rt_en_i
);
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rd_word;
  logic          we, wrst_n, rrst_n;

  assign wrst_n = rst_ni & prst_ni;
  assign rrst_n = rst_ni & prst_ni;

  dmf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .raddr_i(raddr),
    .rdata_o(rd_word)
  );

  dmf_gray_sync #(.W(PW)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(wrst_n),
    .d_i   (rgray),
    .q_o   (rgray_s)
  );

  dmf_gray_sync #(.W(PW)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_n),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  dmf_wr_ctrl #(.AW(AW)) u_wr (
    .wclk_i       (wclk_i),
    .rst_ni       (rst_ni),
    .prst_ni      (prst_ni),
    .fwft_sel_i   (fwft_sel_i),
    .wr_en_i      (wr_en_i),
    .af_lvl_i     (af_lvl_i),
    .rgray_s_i    (rgray_s),
    .wgray_o      (wgray),
    .waddr_o      (waddr),
    .we_o         (we),
    .wr_flag_o    (wr_flag_o),
    .almost_full_o(almost_full_o)
  );

  dmf_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i        (rclk_i),
    .rst_ni        (rst_ni),
    .prst_ni       (prst_ni),
    .fwft_sel_i    (fwft_sel_i),
    .rd_en_i       (rd_en_i),
    .rt_i          (rt_i),
    .rt_en_i       (rt_en_i),
    .ae_lvl_i      (ae_lvl_i),
    .wgray_s_i     (wgray_s),
    .rd_word_i     (rd_word),
    .rgray_o       (rgray),
    .raddr_o       (raddr),
    .rdata_o       (rdata_o),
    .rd_flag_o     (rd_flag_o),
    .almost_empty_o(almost_empty_o)
  );
endmodule

// File: tb/dmf_fifo_tb_top.sv
`timescale 1ns/1ps
module dmf_fifo_tb_top;
  localparam int DW = 36;
  localparam int AW = 6;
  localparam int PW = AW + 1;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          rst_ni = 1'b0, prst_ni = 1'b1, fwft_sel_i = 1'b0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0, rt_i = 1'b0, rt_en_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [PW-1:0] af_lvl_i = PW'(4), ae_lvl_i = PW'(4);
  logic          wr_flag_o, almost_full_o, rd_flag_o, almost_empty_o;
  logic [DW-1:0] rdata_o;

  int n_chk = 0, n_fail = 0, n_acc = 0;
  bit tb_fwft = 1'b0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_rd = '0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dmf_fifo #(.DW(DW), .AW(AW)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .prst_ni(prst_ni),
    .fwft_sel_i(fwft_sel_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .wr_flag_o(wr_flag_o), .almost_full_o(almost_full_o), .af_lvl_i(af_lvl_i),
    .rd_en_i(rd_en_i), .rdata_o(rdata_o), .rd_flag_o(rd_flag_o),
    .almost_empty_o(almost_empty_o), .ae_lvl_i(ae_lvl_i),
    .rt_i(rt_i), .rt_en_i(rt_en_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom_range(15, 0), $urandom()};
  endfunction

  task automatic settle();
    repeat (10) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic mreset(input bit fwft);
    wr_en_i = 1'b0; rd_en_i = 1'b0; rt_i = 1'b0;
    rst_ni = 1'b0; fwft_sel_i = fwft;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst_ni = 1'b1;
    tb_fwft = fwft;
    q.delete();
  endtask

  task automatic preset();
    @(negedge wclk);
    prst_ni = 1'b0;
    #11;
    prst_ni = 1'b1;
    q.delete();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    bit acc;
    @(negedge wclk);
    acc = tb_fwft ? wr_flag_o : ~wr_flag_o;
    wr_en_i = 1'b1; wdata_i = d;
    if (acc) begin q.push_back(d); n_acc++; end
    @(negedge wclk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_std(input string req, output bit ok);
    logic [DW-1:0] e;
    @(negedge rclk);
    ok = ~rd_flag_o;
    rd_en_i = 1'b1;
    @(negedge rclk);
    rd_en_i = 1'b0;
    if (ok) begin
      e = q.pop_front();
      chk(rdata_o == e, req, "std read data", 64'(rdata_o), 64'(e));
      last_rd = rdata_o;
    end
  endtask

  task automatic rd_fwft(input string req);
    @(negedge rclk);
    if (rd_flag_o) begin
      chk(q.size() > 0 && rdata_o == q[0], req, "fwft head data", 64'(rdata_o),
          64'(q.size() > 0 ? q[0] : '0));
      if (q.size() > 0) void'(q.pop_front());
    end
    rd_en_i = 1'b1;
    @(negedge rclk);
    rd_en_i = 1'b0;
  endtask

  task automatic writer(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      int pct;
      bit acc;
      logic [DW-1:0] d;
      @(negedge wclk);
      pct = (i < cycles / 2) ? 75 : 30;
      acc = tb_fwft ? wr_flag_o : ~wr_flag_o;
      if ($urandom_range(99, 0) < pct) begin
        d = rnd_word();
        wr_en_i = 1'b1; wdata_i = d;
        if (acc) q.push_back(d);
      end else begin
        wr_en_i = 1'b0;
      end
    end
    @(negedge wclk);
    wr_en_i = 1'b0;
  endtask

  task automatic reader(input int cycles, input int pct_lo, input int pct_hi, input bit drain);
    bit pend = 1'b0;
    logic [DW-1:0] pexp = '0;
    for (int i = 0; i < cycles; i++) begin
      int pct;
      bit rd;
      @(negedge rclk);
      if (!tb_fwft && pend)
        chk(rdata_o == pexp, "R4", "random std data", 64'(rdata_o), 64'(pexp));
      if (tb_fwft && rd_flag_o)
        chk(q.size() > 0 && rdata_o == q[0], "R4", "random fwft data", 64'(rdata_o),
            64'(q.size() > 0 ? q[0] : '0));
      pct = (i < cycles / 2) ? pct_lo : pct_hi;
      rd = ($urandom_range(99, 0) < pct);
      pend = 1'b0;
      if (tb_fwft) begin
        if (rd && rd_flag_o && q.size() > 0) void'(q.pop_front());
      end else if (rd && !rd_flag_o && q.size() > 0) begin
        pexp = q.pop_front();
        pend = 1'b1;
      end
      rd_en_i = rd;
      if (drain && !pend && q.size() == 0 && i > 20) break;
    end
    @(negedge rclk);
    rd_en_i = 1'b0;
    if (!tb_fwft && pend)
      chk(rdata_o == pexp, "R4", "random std last data", 64'(rdata_o), 64'(pexp));
  endtask

  task automatic random_phase();
    fork
      writer(800);
      reader(600, 30, 85, 1'b0);
    join
    reader(1500, 100, 100, 1'b1);
    settle();
    chk(q.size() == 0, "R4", "model drained", 64'(q.size()), 64'd0);
    chk(rd_flag_o == !tb_fwft, "R4", "no data after drain", 64'(rd_flag_o), 64'(!tb_fwft));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    logic [DW-1:0] d0, ra, rb, rc;
    void'($urandom(32'd4711));

    // standard mode, reset state
    mreset(1'b0);
    chk(rd_flag_o == 1'b1, "R8", "std empty after reset", 64'(rd_flag_o), 64'd1);
    chk(wr_flag_o == 1'b0, "R8", "std not full after reset", 64'(wr_flag_o), 64'd0);
    chk(almost_empty_o == 1'b1, "R8", "almost empty after reset", 64'(almost_empty_o), 64'd1);
    chk(almost_full_o == 1'b0, "R7", "almost full after reset", 64'(almost_full_o), 64'd0);

    // mode pin flipped after reset must be ignored
    fwft_sel_i = 1'b1;
    d0 = 36'h9_1234_5678;
    wr_word(d0);
    settle();
    chk(rd_flag_o == 1'b0, "R2", "std not empty after write", 64'(rd_flag_o), 64'd0);
    chk(rdata_o == '0, "R1", "no fall-through after pin change", 64'(rdata_o), 64'd0);
    rd_std("R2", ok);
    chk(ok, "R2", "std read accepted", 64'(ok), 64'd1);
    settle();
    chk(rd_flag_o == 1'b1, "R2", "std empty after read", 64'(rd_flag_o), 64'd1);

    // thresholds and full boundary
    n_acc = 0;
    for (int i = 0; i < 4; i++) wr_word(36'hA_0000_0000 + 36'(i));
    settle();
    chk(almost_empty_o == 1'b1, "R6", "ae at count 4", 64'(almost_empty_o), 64'd1);
    wr_word(36'hA_0000_0004);
    settle();
    chk(almost_empty_o == 1'b0, "R6", "ae at count 5", 64'(almost_empty_o), 64'd0);
    for (int i = 5; i < 60; i++) wr_word(36'hA_0000_0000 + 36'(i));
    settle();
    chk(almost_full_o == 1'b0, "R7", "af at count 60", 64'(almost_full_o), 64'd0);
    wr_word(36'hA_0000_003C);
    settle();
    chk(almost_full_o == 1'b1, "R7", "af at count 61", 64'(almost_full_o), 64'd1);
    for (int i = 61; i < 64; i++) wr_word(36'hA_0000_0000 + 36'(i));
    chk(wr_flag_o == 1'b1, "R2", "full at 64", 64'(wr_flag_o), 64'd1);
    for (int i = 0; i < 6; i++) wr_word(36'hF_FFFF_FFFF);
    chk(n_acc == 64, "R5", "writes accepted when full", 64'(n_acc), 64'd64);
    for (int i = 0; i < 64; i++) rd_std("R5", ok);
    settle();
    chk(rd_flag_o == 1'b1, "R2", "empty after drain", 64'(rd_flag_o), 64'd1);
    rd_std("R5", ok);
    chk(!ok, "R5", "read while empty refused", 64'(ok), 64'd0);
    chk(rdata_o == 36'hA_0000_003F, "R5", "rdata held on empty read", 64'(rdata_o),
        64'h0A_0000_003F);

    // fall-through mode
    mreset(1'b1);
    chk(rd_flag_o == 1'b0, "R8", "fwft no data after reset", 64'(rd_flag_o), 64'd0);
    chk(wr_flag_o == 1'b1, "R3", "fwft input ready after reset", 64'(wr_flag_o), 64'd1);
    d0 = 36'h5_CAFE_F00D;
    wr_word(d0);
    settle();
    chk(rd_flag_o == 1'b1, "R3", "fwft output ready", 64'(rd_flag_o), 64'd1);
    chk(rdata_o == d0, "R3", "first word falls through", 64'(rdata_o), 64'(d0));
    wr_word(36'h5_0000_0001);
    wr_word(36'h5_0000_0002);
    settle();
    for (int i = 0; i < 3; i++) rd_fwft("R3");
    settle();
    chk(rd_flag_o == 1'b0, "R3", "fwft not ready after reads", 64'(rd_flag_o), 64'd0);

    // partial reset keeps mode
    wr_word(36'h6_0000_0001);
    wr_word(36'h6_0000_0002);
    settle();
    preset();
    settle();
    chk(rd_flag_o == 1'b0, "R8", "no data after partial reset", 64'(rd_flag_o), 64'd0);
    chk(wr_flag_o == 1'b1, "R8", "space after partial reset", 64'(wr_flag_o), 64'd1);
    chk(almost_empty_o == 1'b1, "R8", "ae after partial reset", 64'(almost_empty_o), 64'd1);
    d0 = 36'h7_7777_0000;
    wr_word(d0);
    settle();
    chk(rd_flag_o == 1'b1 && rdata_o == d0, "R8", "fwft kept over partial reset",
        64'(rdata_o), 64'(d0));

    // retransmit
    preset();
    ra = 36'h1_0000_00AA; rb = 36'h1_0000_00BB; rc = 36'h1_0000_00CC;
    wr_word(ra); wr_word(rb); wr_word(rc);
    settle();
    for (int i = 0; i < 3; i++) rd_fwft("R4");
    settle();
    @(negedge rclk); rt_en_i = 1'b0; rt_i = 1'b1;
    @(negedge rclk); rt_i = 1'b0;
    settle();
    chk(rd_flag_o == 1'b0, "R9", "rt without enable ignored", 64'(rd_flag_o), 64'd0);
    @(negedge rclk); rt_en_i = 1'b1; rt_i = 1'b1;
    @(negedge rclk); rt_i = 1'b0; rt_en_i = 1'b0;
    q.push_back(ra); q.push_back(rb); q.push_back(rc);
    settle();
    chk(rd_flag_o == 1'b1 && rdata_o == ra, "R9", "rt replays first word", 64'(rdata_o), 64'(ra));
    for (int i = 0; i < 3; i++) rd_fwft("R9");
    settle();
    chk(rd_flag_o == 1'b0, "R9", "rt replay ends", 64'(rd_flag_o), 64'd0);

    // random traffic, both modes
    preset();
    settle();
    random_phase();
    mreset(1'b0);
    settle();
    random_phase();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule